// File: doc/BRIEF.md
# JTAG scan command engine

The engine turns a byte stream of scan commands, written by a processor, into activity on a JTAG port: it generates TCK from the system clock and drives TMS and TDI. Commands come in two kinds. A TMS command steps the far-end TAP state machine through a short bit sequence. A shift command moves a payload of 1 to 128 bits through TDI. It can also collect the TDO bits that come back. All of this is LSB first.

The processor pushes bytes into a write FIFO through three strobes: one byte, two bytes or four bytes per write. It polls a status word for the busy flag and the FIFO fill level. Captured TDO data is packed into 32-bit words and read from a small read FIFO. A chain-select register connects one scan chain at a time.

Top module: `scan_cmd_engine`

## Requirements
- R1: After reset, TCK is 1, TMS and TDI are 0, the status word is 0, rd_valid is 0 and chain_sel is 0.
- R2: Bit 7 of a command byte selects its kind: 0 is a TMS command, 1 is a shift command. In a TMS command, the highest set bit of bits 5:0 marks the sequence length n. The n bits below it go out on TMS one per TCK pulse, bit 0 first. TDI stays 0. An argument of 0 or 1 produces no pulses.
- R3: A shift command byte is followed by a length byte whose bits 6:0 hold the bit count minus one (0 gives 1 bit, 127 gives 128 bits). Exactly that many TCK pulses follow. The payload bytes are taken in FIFO order, and each byte is sent from bit 0 upward. TDI holds the payload bit at each rising TCK edge.
- R4: During a payload shift, TMS is 0 at every rising TCK edge except the last, where it is 1.
- R5: Bit 2 of a shift command byte enables capture. TDO is sampled on each rising TCK edge and packed bit 0 first into 32-bit words. A word goes to the read FIFO when it holds 32 bits or the payload ends; a final partial word has its unused upper bits at 0. When bit 2 is 0, nothing is captured.
- R6: rd_data shows the oldest captured word while rd_valid is 1. A cycle with rd_en high removes that word, and words come out in capture order.
- R7: wr1_en pushes wr_data[7:0]. wr2_en pushes wr_data[7:0] and then wr_data[15:8]. wr4_en pushes the four bytes of wr_data, lowest first. A write that does not fit in the free space of the 8-byte write FIFO is dropped whole.
- R8: Status bit 31 is 1 while a command is executing. Bits 30:28 give the write FIFO occupancy in bytes, saturating at 7. All other bits are 0. The engine is idle when bits 31:28 are 0.
- R9: A chain_wr with at most one bit set in chain_wdata loads it into chain_sel. A chain_wr with more than one bit set leaves chain_sel unchanged.
- R10: TCK rests high. Each bit takes 2*HALF clock cycles (4 by default), and TCK falls at the start of the bit. TMS and TDI change only together with a falling TCK edge and stay stable while TCK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr1_en | input | 1 | Push one byte |
| wr2_en | input | 1 | Push two bytes |
| wr4_en | input | 1 | Push four bytes |
| wr_data | input | 32 | Write data, lowest byte first |
| rd_en | input | 1 | Pop one captured word |
| rd_data | output | 32 | Oldest captured word |
| rd_valid | output | 1 | Read FIFO holds a word |
| status | output | 32 | Busy flag and write FIFO occupancy |
| chain_wr | input | 1 | Write the chain-select register |
| chain_wdata | input | NCHAIN | New chain-select value |
| chain_sel | output | NCHAIN | Enabled scan chain, one-hot or zero |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
Two functions share one cycle. A processor push can land on the write FIFO in the same cycle that the engine pops its next command or payload byte. Likewise, a capture word can reach the read FIFO while the processor is reading. The 128-bit shift provokes the first case: its 4-byte payload writes are issued while the engine drains bytes between bits. It is judged by the exact pulse count, the TDI pattern and the four captured words, which the bench computes from the loopback TDO. The overflow case fills the FIFO while the engine is stalled inside a TMS sequence. The dropped command must produce no pulses, and the status word must read full and busy.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEN,
        ST_LOAD,
        ST_BIT
    } eng_state_t;

    typedef struct packed {
        logic       shift;
        logic       capture;
        logic [5:0] tms_bits;
        logic [2:0] tms_len;
    } cmd_t;

    // index of the highest set bit above bit 0; zero when none
    function automatic logic [2:0] tms_span(input logic [5:0] a);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 1; i < 6; i++) begin
            if (a[i]) r = 3'(i);
        end
        return r;
    endfunction

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.shift    = b[7];
        c.capture  = b[2];
        c.tms_bits = b[5:0];
        c.tms_len  = tms_span(b[5:0]);
        return c;
    endfunction

endpackage

// File: rtl/scan_wfifo.sv
module scan_wfifo #(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [2:0]                   push_n,
    input  logic [scan_pkg::WORD_W-1:0]  push_data,
    input  logic                         pop,
    output logic [scan_pkg::BYTE_W-1:0]  head,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [scan_pkg::BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          accept;

    assign accept = (push_n != 3'd0) && ((int'(count) + int'(push_n)) <= DEPTH);
    assign head   = mem[rptr];
    assign empty  = (count == '0);

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int i = 0; i < 4; i++) begin
                if (i < int'(push_n)) mem[wptr + AW'(i)] <= push_data[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (accept) wptr <= wptr + AW'(push_n);
            if (pop)    rptr <= rptr + AW'(1);
            count <= count + (accept ? CW'(push_n) : CW'(0)) - (pop ? CW'(1) : CW'(0));
        end
    end
endmodule

// File: rtl/scan_rfifo.sv
module scan_rfifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             valid
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             wr_ok, rd_ok;

    assign wr_ok = push && (int'(cnt) < DEPTH);
    assign rd_ok = pop && valid;
    assign valid = (cnt != '0);
    assign dout  = mem[rptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + AW'(1);
            if (rd_ok) rptr <= rptr + AW'(1);
            cnt <= cnt + (wr_ok ? CW'(1) : CW'(0)) - (rd_ok ? CW'(1) : CW'(0));
        end
    end
endmodule

// File: rtl/scan_shifter.sv
module scan_shifter
    import scan_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_head,
    output logic              fifo_pop,
    output logic              busy,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo,
    output logic              cap_push,
    output logic [WORD_W-1:0] cap_data
);
    localparam int PW = (2 * HALF > 1) ? $clog2(2 * HALF) : 1;

    eng_state_t        st;
    cmd_t              cur;
    logic [PW-1:0]     ph;
    logic [BYTE_W-1:0] sreg;
    logic [7:0]        left;
    logic [2:0]        bidx;
    logic              tms_mode, cap_en;
    logic [WORD_W-1:0] cap_word;
    logic [4:0]        cap_n;
    logic              last_bit;

    assign cur      = decode_cmd(fifo_head);
    assign busy     = (st != ST_IDLE);
    assign fifo_pop = (st != ST_BIT) && !fifo_empty;
    assign last_bit = (left == 8'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            tck      <= 1'b1;
            tms      <= 1'b0;
            tdi      <= 1'b0;
            ph       <= '0;
            sreg     <= '0;
            left     <= '0;
            bidx     <= '0;
            tms_mode <= 1'b0;
            cap_en   <= 1'b0;
            cap_word <= '0;
            cap_n    <= '0;
            cap_push <= 1'b0;
            cap_data <= '0;
        end else begin
            cap_push <= 1'b0;
            case (st)
                ST_IDLE: if (!fifo_empty) begin
                    if (!cur.shift) begin
                        if (cur.tms_len != 3'd0) begin
                            sreg     <= {2'b00, cur.tms_bits};
                            left     <= 8'(cur.tms_len);
                            tms_mode <= 1'b1;
                            ph       <= '0;
                            st       <= ST_BIT;
                        end
                    end else begin
                        cap_en   <= cur.capture;
                        tms_mode <= 1'b0;
                        st       <= ST_LEN;
                    end
                end
                ST_LEN: if (!fifo_empty) begin
                    left <= {1'b0, fifo_head[6:0]} + 8'd1;
                    st   <= ST_LOAD;
                end
                ST_LOAD: if (!fifo_empty) begin
                    sreg <= fifo_head;
                    bidx <= '0;
                    ph   <= '0;
                    st   <= ST_BIT;
                end
                ST_BIT: begin
                    if (ph == '0) begin
                        tck <= 1'b0;
                        tms <= tms_mode ? sreg[0] : last_bit;
                        tdi <= tms_mode ? 1'b0 : sreg[0];
                    end
                    if (int'(ph) == HALF) begin
                        tck <= 1'b1;
                        if (!tms_mode && cap_en) begin
                            if (cap_n == 5'd31 || last_bit) begin
                                cap_push <= 1'b1;
                                cap_data <= cap_word | (WORD_W'(tdo) << cap_n);
                                cap_word <= '0;
                                cap_n    <= '0;
                            end else begin
                                cap_word <= cap_word | (WORD_W'(tdo) << cap_n);
                                cap_n    <= cap_n + 5'd1;
                            end
                        end
                    end
                    if (int'(ph) == 2 * HALF - 1) begin
                        ph   <= '0;
                        sreg <= sreg >> 1;
                        left <= left - 8'd1;
                        bidx <= bidx + 3'd1;
                        if (last_bit) st <= ST_IDLE;
                        else if (!tms_mode && bidx == 3'd7) st <= ST_LOAD;
                    end else begin
                        ph <= ph + PW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scan_cmd_engine.sv
module scan_cmd_engine
    import scan_pkg::*;
#(
    parameter int WF_DEPTH = 8,
    parameter int RF_DEPTH = 4,
    parameter int HALF     = 2,
    parameter int NCHAIN   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr1_en,
    input  logic              wr2_en,
    input  logic              wr4_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [31:0]       status,
    input  logic              chain_wr,
    input  logic [NCHAIN-1:0] chain_wdata,
    output logic [NCHAIN-1:0] chain_sel,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);
    localparam int WF_CW = $clog2(WF_DEPTH + 1);

    logic [2:0]        push_n;
    logic              wf_pop, wf_empty, busy, cap_push;
    logic [BYTE_W-1:0] wf_head;
    logic [WF_CW-1:0]  wf_cnt;
    logic [WORD_W-1:0] cap_data;
    logic [2:0]        occ;

    assign push_n = wr4_en ? 3'd4 : wr2_en ? 3'd2 : wr1_en ? 3'd1 : 3'd0;
    assign occ    = (int'(wf_cnt) > 7) ? 3'd7 : 3'(wf_cnt);
    assign status = {busy, occ, 28'd0};

    scan_wfifo #(.DEPTH(WF_DEPTH)) u_wfifo (
        .clk(clk), .rst(rst), .push_n(push_n), .push_data(wr_data),
        .pop(wf_pop), .head(wf_head), .empty(wf_empty), .count(wf_cnt)
    );

    scan_shifter #(.HALF(HALF)) u_shift (
        .clk(clk), .rst(rst), .fifo_empty(wf_empty), .fifo_head(wf_head),
        .fifo_pop(wf_pop), .busy(busy), .tck(tck), .tms(tms), .tdi(tdi),
        .tdo(tdo), .cap_push(cap_push), .cap_data(cap_data)
    );

    scan_rfifo #(.WIDTH(WORD_W), .DEPTH(RF_DEPTH)) u_rfifo (
        .clk(clk), .rst(rst), .push(cap_push), .din(cap_data),
        .pop(rd_en), .dout(rd_data), .valid(rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) chain_sel <= '0;
        else if (chain_wr && $onehot0(chain_wdata)) chain_sel <= chain_wdata;
    end
endmodule

// File: rtl/scan_cmd_engine_chk.sv
module scan_cmd_engine_chk #(
    parameter int NCHAIN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              tck,
    input logic              tms,
    input logic              tdi,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [NCHAIN-1:0] chain_sel
);
    p_chain_single_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chain_sel));

    p_tck_rest_high_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tck);

    p_pins_stable_high_r10: assert property (@(posedge clk) disable iff (rst)
        (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

    p_fall_needs_busy_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(tck) |-> $past(busy));

    p_read_only_by_pop_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> $past(rd_en));
endmodule

bind scan_cmd_engine scan_cmd_engine_chk #(.NCHAIN(NCHAIN)) u_chk (
    .clk(clk), .rst(rst), .busy(status[31]), .tck(tck), .tms(tms), .tdi(tdi),
    .rd_en(rd_en), .rd_valid(rd_valid), .chain_sel(chain_sel)
);

// File: tb/sim_scan_cmd_engine.sv
module sim_scan_cmd_engine;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr1_en = 1'b0, wr2_en = 1'b0, wr4_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [31:0] rd_data, status;
    logic rd_valid;
    logic chain_wr = 1'b0;
    logic [NCH-1:0] chain_wdata = '0;
    logic [NCH-1:0] chain_sel;
    logic tck, tms, tdi, tdo;

    assign tdo = ~tdi;   // loopback: captured data is the inverted payload

    always #10 clk = ~clk;

    scan_cmd_engine #(.NCHAIN(NCH)) u0 (
        .clk(clk), .rst(rst), .wr1_en(wr1_en), .wr2_en(wr2_en), .wr4_en(wr4_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .status(status), .chain_wr(chain_wr), .chain_wdata(chain_wdata),
        .chain_sel(chain_sel), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    int checks = 0;
    int fails  = 0;

    // pin monitor, sampled away from the active edge
    logic mon_clr = 1'b0;
    logic prev_tck = 1'b1, prev_tms = 1'b0, prev_tdi = 1'b0;
    int cyc = 0, last_rise = 0;
    int mon_n = 0, mon_ones = 0, mon_last_one = -1, mon_gap = 0, mon_viol = 0;
    logic [31:0] mon_tms = '0, mon_tdi = '0;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            mon_n = 0; mon_ones = 0; mon_last_one = -1; mon_gap = 0; mon_viol = 0;
            mon_tms = '0; mon_tdi = '0;
        end else begin
            if (tck && !prev_tck) begin
                if (mon_n < 32) begin
                    mon_tms[mon_n] = tms;
                    mon_tdi[mon_n] = tdi;
                end
                if (tms) begin mon_ones++; mon_last_one = mon_n; end
                if (mon_n == 1) mon_gap = cyc - last_rise;
                last_rise = cyc;
                mon_n++;
            end
            if (tck && prev_tck && (tms != prev_tms || tdi != prev_tdi)) mon_viol++;
        end
        prev_tck = tck; prev_tms = tms; prev_tdi = tdi;
    end

    typedef struct packed {
        logic        kind;
        logic [5:0]  arg;
        logic [7:0]  len;
        logic [31:0] pay;
        logic [7:0]  n;
        logic [31:0] etms;
        logic [31:0] etdi;
        logic        cap;
        logic [31:0] ecap;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'h3F, 8'd0,  32'h0,        8'd5,  32'h1F,       32'h0,        1'b0, 32'h0},
        '{1'b0, 6'h12, 8'd0,  32'h0,        8'd4,  32'h2,        32'h0,        1'b0, 32'h0},
        '{1'b0, 6'h01, 8'd0,  32'h0,        8'd0,  32'h0,        32'h0,        1'b0, 32'h0},
        '{1'b0, 6'h20, 8'd0,  32'h0,        8'd5,  32'h0,        32'h0,        1'b0, 32'h0},
        '{1'b1, 6'h00, 8'd8,  32'hA5,       8'd8,  32'h80,       32'hA5,       1'b0, 32'h0},
        '{1'b1, 6'h04, 8'd32, 32'h12345678, 8'd32, 32'h80000000, 32'h12345678, 1'b1, 32'hEDCBA987},
        '{1'b1, 6'h04, 8'd5,  32'h13,       8'd5,  32'h10,       32'h13,       1'b1, 32'h0000000C},
        '{1'b1, 6'h0C, 8'd12, 32'hABC,      8'd12, 32'h800,      32'hABC,      1'b1, 32'h00000543},
        '{1'b1, 6'h03, 8'd1,  32'h1,        8'd1,  32'h1,        32'h1,        1'b0, 32'h0}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    task automatic wr(input int nb, input logic [31:0] d);
        @(negedge clk);
        wr_data = d;
        wr1_en = (nb == 1); wr2_en = (nb == 2); wr4_en = (nb == 4);
        @(negedge clk);
        wr1_en = 1'b0; wr2_en = 1'b0; wr4_en = 1'b0;
    endtask

    task automatic wait_room(input int nb);
        while (int'(status[30:28]) + nb > 7) @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (status[31:28] != 4'h0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pop_word();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic send_shift(input logic [3:0] arg, input int len, input logic [127:0] pay);
        int nbytes, i;
        wait_room(2);
        wr(2, {16'h0, 8'(len - 1), 4'h8, arg});
        nbytes = (len + 7) / 8;
        i = 0;
        while (i < nbytes) begin
            if (nbytes - i >= 4) begin
                wait_room(4);
                wr(4, pay[8*i +: 32]);
                i += 4;
            end else begin
                wait_room(1);
                wr(1, {24'h0, pay[8*i +: 8]});
                i += 1;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] big;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(status == 32'h0, "R1 status", status, 32'h0);
        chk(tck == 1'b1 && tms == 1'b0 && tdi == 1'b0, "R1 pins", {29'h0, tck, tms, tdi}, 32'h4);
        chk(!rd_valid, "R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        chk(chain_sel == '0, "R1 chain_sel", 32'(chain_sel), 32'h0);

        // table of commands: R2 R3 R4 R5 R10
        for (int v = 0; v < NV; v++) begin
            clear_mon();
            if (!VEC[v].kind) wr(1, {24'h0, 2'b00, VEC[v].arg});
            else send_shift(VEC[v].arg[3:0], int'(VEC[v].len), {96'h0, VEC[v].pay});
            wait_idle();
            chk(mon_n == int'(VEC[v].n), "R2/R3 pulse count", 32'(mon_n), 32'(VEC[v].n));
            chk(mon_tms == VEC[v].etms, "R2/R4 tms bits", mon_tms, VEC[v].etms);
            chk(mon_tdi == VEC[v].etdi, "R3 tdi bits", mon_tdi, VEC[v].etdi);
            chk(mon_viol == 0, "R10 pins stable while tck high", 32'(mon_viol), 32'h0);
            if (v == 0) chk(mon_gap == 4, "R10 bit period", 32'(mon_gap), 32'd4);
            if (VEC[v].cap) begin
                chk(rd_valid && rd_data == VEC[v].ecap, "R5 captured word", rd_data, VEC[v].ecap);
                pop_word();
                chk(!rd_valid, "R6 read fifo empty after pop", {31'h0, rd_valid}, 32'h0);
            end else begin
                chk(!rd_valid, "R5 no capture", {31'h0, rd_valid}, 32'h0);
            end
        end

        // R3 R4 R5 R6: full 128-bit payload with capture
        big = {32'h13579BDF, 32'h80000001, 32'h0F0FF0F0, 32'hDEADBEEF};
        clear_mon();
        send_shift(4'h4, 128, big);
        wait_idle();
        chk(mon_n == 128, "R3 128-bit pulse count", 32'(mon_n), 32'd128);
        chk(mon_ones == 1 && mon_last_one == 127, "R4 tms only on last bit", 32'(mon_last_one), 32'd127);
        chk(mon_tdi == 32'hDEADBEEF, "R3 first word on tdi", mon_tdi, 32'hDEADBEEF);
        for (int w = 0; w < 4; w++) begin
            chk(rd_valid && rd_data == ~big[32*w +: 32], "R6 capture word order", rd_data, ~big[32*w +: 32]);
            pop_word();
        end
        chk(!rd_valid, "R6 drained", {31'h0, rd_valid}, 32'h0);

        // R7 R8: fill the write fifo while the engine is stalled in a TMS walk
        clear_mon();
        wr(1, 32'h20);
        repeat (3) @(negedge clk);
        wr(4, 32'h0);
        wr(4, 32'h0);
        wr(1, 32'h3F);
        chk(status == 32'hF000_0000, "R8 full and busy", status, 32'hF000_0000);
        wait_idle();
        chk(status == 32'h0, "R8 idle", status, 32'h0);
        chk(mon_n == 5, "R7 overflow write dropped", 32'(mon_n), 32'd5);

        // R9 chain select
        @(negedge clk); chain_wr = 1'b1; chain_wdata = 4'b0100;
        @(negedge clk); chain_wr = 1'b0;
        chk(chain_sel == 4'b0100, "R9 single chain", 32'(chain_sel), 32'h4);
        @(negedge clk); chain_wr = 1'b1; chain_wdata = 4'b0110;
        @(negedge clk); chain_wr = 1'b0;
        chk(chain_sel == 4'b0100, "R9 multi-bit ignored", 32'(chain_sel), 32'h4);
        @(negedge clk); chain_wr = 1'b1; chain_wdata = 4'b0000;
        @(negedge clk); chain_wr = 1'b0;
        chk(chain_sel == 4'b0000, "R9 cleared", 32'(chain_sel), 32'h0);

        summary();
        $finish;
    end
endmodule